// File: doc/BRIEF.md
# Write-Leveling Responder

This block models the memory-device side of a write-leveling calibration. A controller writes mode register 1 to put the device into leveling mode, then sends single rising edges on the data strobe. On each edge the device captures the level of the memory clock. After a fixed latency it returns that level on every data bit, so the controller can move its strobe delay until it sees the feedback change from 0 to 1.

The model runs on one fast sampling clock `clk`. The memory clock `mem_ck`, the strobe `dqs` and the termination pin `odt` are inputs whose levels it samples. The mode-register write also carries an output-off control: with the outputs switched off, the data bus stays undriven but capture goes on inside the block. While leveling, the block reports two things. It flags any command that is not allowed in this mode, and it flags a nominal termination code that is not allowed while the outputs are driven. It also shows which terminations are switched on.

Top module: `wlvl_responder`

## Requirements
- R1: A mode-register write (`cs_n`=0, `cmd`=3'b000, `ba`=1) with `addr[7]`=1 enters leveling mode when the block is not leveling. A later write of the same kind with `addr[7]`=0 leaves leveling mode. Each change shows on `dq_oe` at the clock edge that samples the command.
- R2: `addr[12]` of the entering write is the output-off control. With 0, `dq_oe` is 1 while leveling. With 1, `dq_oe` stays 0, but the captured feedback still updates `dq_out`.
- R3: While leveling, `dqs_term_on` equals the `odt` level sampled at the previous clock edge.
- R4: While leveling, `dq_term_on` is 0 whatever the `odt` level. Outside leveling, `dq_term_on` and `dqs_term_on` both follow the previous `odt` sample.
- R5: Suppose a rise of `dqs` (high now, low at the previous edge) is first seen at edge k while leveling. Then `mem_ck` as sampled at edge k appears on the data bits. Each bit holds that value until the next capture reaches it.
- R6: Bit i of `dq_out` takes the new value at edge k + WLO + (i mod (WLOE+1)), so every bit changes within WLOE cycles of the earliest. Defaults are WLO=3 and WLOE=1.
- R7: While leveling, every command except deselect (`cs_n`=1), no-operation (`cmd`=3'b111) and the leveling-exit write sets `illegal_cmd` for one cycle after the edge that samples it. Such a command changes no mode state, including a mode-register-1 write with `addr[7]`=1.
- R8: The nominal termination code is {`addr[9]`,`addr[6]`,`addr[2]`}, where 3'b010, 3'b001 and 3'b011 select resistor/2, /4 and /6. `rtt_bad` is 1 only when the block is leveling, the outputs are enabled and the code is not one of those three.
- R9: Entering leveling mode clears `dq_out` to 0 at the entering edge. Captures still in flight are discarded.
- R10: A rise of `dqs` outside leveling mode captures nothing and leaves `dq_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low; high means deselect |
| cmd | input | 3 | Command code; 3'b000 mode-register write, 3'b111 no-operation |
| ba | input | 3 | Bank address; 1 selects mode register 1 |
| addr | input | 13 | Address / mode-register data |
| mem_ck | input | 1 | Memory clock level to be sampled |
| dqs | input | 1 | Data strobe from the controller |
| odt | input | 1 | On-die-termination control pin |
| dq_out | output | 8 | Leveling feedback on all data bits |
| dq_oe | output | 1 | Data output enable |
| dqs_term_on | output | 1 | Strobe termination active |
| dq_term_on | output | 1 | Data termination active |
| illegal_cmd | output | 1 | Disallowed command seen while leveling |
| rtt_bad | output | 1 | Disallowed nominal termination code for the output state |

## Verification
Capture by the strobe and command decode can fall into the same cycle. A strobe rise can be seen at the very edge where an illegal command, or the exit write, is sampled. The bench launches a strobe pulse and places a disallowed command in the same cycle. It then checks that the error flag rises, that the mode is unchanged, and that the feedback still arrives at its usual per-bit time. A second pairing places the termination pin's change in the cycle after an entering write. The flags must then follow the new mode at once.

// File: rtl/wlvl_pkg.sv
package wlvl_pkg;

  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_ZQ  = 3'b110,
    CMD_NOP = 3'b111
  } cmd_e;

  localparam logic [2:0] MR1_BANK = 3'd1;
  localparam int LVL_BIT  = 7;
  localparam int QOFF_BIT = 12;
  localparam int RTT_HI   = 9;
  localparam int RTT_MID  = 6;
  localparam int RTT_LO   = 2;

  // Nominal termination codes permitted while outputs are driven.
  function automatic logic rtt_ok_driven(input logic [2:0] code);
    logic ok;
    case (code)
      3'b001, 3'b010, 3'b011: ok = 1'b1;
      default:                ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/wlvl_rst_sync.sv
module wlvl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/wlvl_mode_ctl.sv
module wlvl_mode_ctl
  import wlvl_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic [2:0]        cmd,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  output logic              lvl_mode,
  output logic              qoff,
  output logic [2:0]        rtt_code,
  output logic              enter_now,
  output logic              illegal_cmd
);
  logic       lvl_q, lvl_d;
  logic       qoff_q, qoff_d;
  logic [2:0] rtt_q, rtt_d;
  logic       err_q, err_d;
  logic       upd_en;
  logic       is_mr1;
  logic       allowed;

  always_comb begin
    is_mr1  = !cs_n && (cmd == CMD_MRS) && (ba == BA_W'(MR1_BANK));
    allowed = cs_n || (cmd == CMD_NOP) || (is_mr1 && !addr[LVL_BIT]);
    if (lvl_q) begin
      upd_en = is_mr1 && !addr[LVL_BIT];
      err_d  = !allowed;
    end else begin
      upd_en = is_mr1;
      err_d  = 1'b0;
    end
    enter_now = upd_en && !lvl_q && addr[LVL_BIT];
    lvl_d  = addr[LVL_BIT];
    qoff_d = addr[QOFF_BIT];
    rtt_d  = {addr[RTT_HI], addr[RTT_MID], addr[RTT_LO]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      qoff_q <= 1'b0;
      rtt_q  <= 3'b000;
    end else if (upd_en) begin
      lvl_q  <= lvl_d;
      qoff_q <= qoff_d;
      rtt_q  <= rtt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign lvl_mode    = lvl_q;
  assign qoff        = qoff_q;
  assign rtt_code    = rtt_q;
  assign illegal_cmd = err_q;
endmodule

// File: rtl/wlvl_sampler.sv
module wlvl_sampler #(
  parameter int DQ_W = 8,
  parameter int WLO  = 3,
  parameter int WLOE = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lvl_mode,
  input  logic            enter_now,
  input  logic            mem_ck,
  input  logic            dqs,
  output logic [DQ_W-1:0] dq_val
);
  localparam int DEPTH    = WLO + WLOE;
  localparam int SKEW_MOD = WLOE + 1;

  logic             dqs_q;
  logic             rise;
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [DEPTH-1:0] val_q, val_d;

  always_comb begin
    rise = dqs && !dqs_q;
    if (enter_now) begin
      vld_d = '0;
      val_d = '0;
    end else begin
      vld_d[0] = rise && lvl_mode;
      val_d[0] = mem_ck;
      for (int i = 1; i < DEPTH; i++) begin
        vld_d[i] = vld_q[i-1];
        val_d[i] = val_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dqs_q <= 1'b0;
      vld_q <= '0;
      val_q <= '0;
    end else begin
      dqs_q <= dqs;
      vld_q <= vld_d;
      val_q <= val_d;
    end
  end

  for (genvar b = 0; b < DQ_W; b++) begin : g_bit
    localparam int TAP = WLO - 1 + (b % SKEW_MOD);
    logic hold_q, hold_d, hold_en;
    always_comb begin
      hold_en = enter_now || vld_q[TAP];
      hold_d  = enter_now ? 1'b0 : val_q[TAP];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hold_q <= 1'b0;
      else if (hold_en) hold_q <= hold_d;
    end
    assign dq_val[b] = hold_q;
  end
endmodule

// File: rtl/wlvl_term.sv
module wlvl_term (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_mode,
  input  logic odt,
  output logic dqs_term_on,
  output logic dq_term_on
);
  logic dqs_t_q, dqs_t_d;
  logic dq_t_q, dq_t_d;

  always_comb begin
    dqs_t_d = odt;
    dq_t_d  = odt && !lvl_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dqs_t_q <= 1'b0;
      dq_t_q  <= 1'b0;
    end else begin
      dqs_t_q <= dqs_t_d;
      dq_t_q  <= dq_t_d;
    end
  end

  assign dqs_term_on = dqs_t_q;
  assign dq_term_on  = dq_t_q;
endmodule

// File: rtl/wlvl_responder.sv
module wlvl_responder
  import wlvl_pkg::*;
#(
  parameter int DQ_W   = 8,
  parameter int ADDR_W = 13,
  parameter int BA_W   = 3,
  parameter int WLO    = 3,
  parameter int WLOE   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic [2:0]        cmd,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mem_ck,
  input  logic              dqs,
  input  logic              odt,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic              dqs_term_on,
  output logic              dq_term_on,
  output logic              illegal_cmd,
  output logic              rtt_bad
);
  logic       rst_i_n;
  logic       lvl_mode;
  logic       qoff;
  logic [2:0] rtt_code;
  logic       enter_now;

  wlvl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  wlvl_mode_ctl #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_mode (
    .clk(clk), .rst_n(rst_i_n), .cs_n(cs_n), .cmd(cmd), .ba(ba), .addr(addr),
    .lvl_mode(lvl_mode), .qoff(qoff), .rtt_code(rtt_code),
    .enter_now(enter_now), .illegal_cmd(illegal_cmd)
  );

  wlvl_sampler #(.DQ_W(DQ_W), .WLO(WLO), .WLOE(WLOE)) u_smp (
    .clk(clk), .rst_n(rst_i_n), .lvl_mode(lvl_mode), .enter_now(enter_now),
    .mem_ck(mem_ck), .dqs(dqs), .dq_val(dq_out)
  );

  wlvl_term u_term (
    .clk(clk), .rst_n(rst_i_n), .lvl_mode(lvl_mode), .odt(odt),
    .dqs_term_on(dqs_term_on), .dq_term_on(dq_term_on)
  );

  always_comb begin
    dq_oe   = lvl_mode && !qoff;
    rtt_bad = lvl_mode && !qoff && !rtt_ok_driven(rtt_code);
  end
endmodule

// File: rtl/wlvl_responder_chk.sv
module wlvl_responder_chk
  import wlvl_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic [2:0]        cmd,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              odt,
  input logic              lvl_mode,
  input logic              qoff,
  input logic              dq_oe,
  input logic              dqs_term_on,
  input logic              dq_term_on,
  input logic              illegal_cmd
);
  logic mr1_wr;
  assign mr1_wr = !cs_n && (cmd == CMD_MRS) && (ba == BA_W'(MR1_BANK));

  p_enter_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl_mode && mr1_wr && addr[LVL_BIT]) |=> lvl_mode);

  p_exit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_mode && mr1_wr && !addr[LVL_BIT]) |=> !lvl_mode);

  p_qoff_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_mode && qoff) |-> !dq_oe);

  p_dqs_term_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lvl_mode) |-> (dqs_term_on == $past(odt)));

  p_dq_term_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lvl_mode) |-> !dq_term_on);

  p_flag_bad_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_mode && !cs_n && cmd != CMD_NOP && !(mr1_wr && !addr[LVL_BIT]))
      |=> illegal_cmd);

  p_flag_needs_lvl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_cmd |-> $past(lvl_mode));

  p_bad_cmd_no_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_mode && mr1_wr && addr[LVL_BIT]) |=> (lvl_mode && $stable(qoff)));
endmodule

bind wlvl_responder wlvl_responder_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd(cmd), .ba(ba), .addr(addr),
  .odt(odt), .lvl_mode(lvl_mode), .qoff(qoff), .dq_oe(dq_oe),
  .dqs_term_on(dqs_term_on), .dq_term_on(dq_term_on), .illegal_cmd(illegal_cmd)
);

// File: tb/tb_wlvl_responder.sv
module tb_wlvl_responder;
  localparam int DQ_W = 8;
  localparam int WLO  = 3;
  localparam int WLOE = 1;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cs_n;
  logic [2:0]      cmd;
  logic [2:0]      ba;
  logic [12:0]     addr;
  logic            mem_ck;
  logic            dqs;
  logic            odt;
  logic [DQ_W-1:0] dq_out;
  logic            dq_oe;
  logic            dqs_term_on;
  logic            dq_term_on;
  logic            illegal_cmd;
  logic            rtt_bad;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  wlvl_responder #(.DQ_W(DQ_W), .WLO(WLO), .WLOE(WLOE)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd(cmd), .ba(ba), .addr(addr),
    .mem_ck(mem_ck), .dqs(dqs), .odt(odt), .dq_out(dq_out), .dq_oe(dq_oe),
    .dqs_term_on(dqs_term_on), .dq_term_on(dq_term_on),
    .illegal_cmd(illegal_cmd), .rtt_bad(rtt_bad)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // MR1 data word: level bit 7, output-off bit 12, termination code {9,6,2}
  function automatic logic [12:0] mr1(input bit lvl, input bit off, input logic [2:0] rtt);
    logic [12:0] a = '0;
    a[7] = lvl; a[12] = off; a[9] = rtt[2]; a[6] = rtt[1]; a[2] = rtt[0];
    return a;
  endfunction

  task automatic issue(input logic [2:0] c, input logic [2:0] b, input logic [12:0] a);
    @(negedge clk);
    cs_n = 1'b0; cmd = c; ba = b; addr = a;
    @(negedge clk);
    cs_n = 1'b1; cmd = 3'b111; ba = '0; addr = '0;
  endtask

  // Strobe pulse; checks per-bit arrival from the cycle the rise is seen.
  task automatic pulse_chk(input bit lvl_v, input logic [DQ_W-1:0] old_v, input string req);
    logic [DQ_W-1:0] nv;
    nv = {DQ_W{lvl_v}};
    @(negedge clk);
    dqs = 1'b1; mem_ck = lvl_v;
    for (int j = 0; j <= WLO + WLOE; j++) begin
      logic [DQ_W-1:0] exp;
      @(negedge clk);
      dqs = 1'b0;
      for (int b = 0; b < DQ_W; b++)
        exp[b] = (j >= WLO + (b % (WLOE + 1))) ? nv[b] : old_v[b];
      chk(req, dq_out, exp);
    end
    mem_ck = ~lvl_v;
  endtask

  task automatic t_reset;
    chk("reset dq_oe", dq_oe, 0);
    chk("reset dq_out", dq_out, 0);
    chk("reset illegal_cmd", illegal_cmd, 0);
    chk("reset rtt_bad", rtt_bad, 0);
    chk("reset dq_term_on", dq_term_on, 0);
  endtask

  task automatic t_outside;
    odt = 1'b1; tick(1);
    chk("R4 outside dq_term follows odt", dq_term_on, 1);
    chk("R4 outside dqs_term follows odt", dqs_term_on, 1);
    issue(3'b011, 3'd0, '0);
    chk("R7 no flag outside leveling", illegal_cmd, 0);
    @(negedge clk); dqs = 1'b1; mem_ck = 1'b1;
    tick(1); dqs = 1'b0; tick(WLO + WLOE + 2);
    chk("R10 strobe ignored outside leveling", dq_out, 0);
    odt = 1'b0; tick(1);
  endtask

  task automatic t_enter_term;
    issue(3'b000, 3'd1, mr1(1, 0, 3'b001));
    chk("R1 entry raises dq_oe", dq_oe, 1);
    chk("R9 dq_out zero after entry", dq_out, 0);
    chk("R8 RZQ/4 legal with outputs on", rtt_bad, 0);
    odt = 1'b1; tick(1);
    chk("R3 dqs_term on with odt", dqs_term_on, 1);
    chk("R4 dq_term off with odt high", dq_term_on, 0);
    odt = 1'b0; tick(1);
    chk("R3 dqs_term off without odt", dqs_term_on, 0);
  endtask

  task automatic t_sample;
    pulse_chk(1'b1, 8'h00, "R5 R6 capture of high");
    tick(6);
    chk("R5 value held between strobes", dq_out, 8'hFF);
    pulse_chk(1'b0, 8'hFF, "R5 R6 capture of low");
  endtask

  task automatic t_illegal;
    issue(3'b011, 3'd0, '0);
    chk("R7 activate flagged", illegal_cmd, 1);
    tick(1);
    chk("R7 flag is one cycle", illegal_cmd, 0);
    // disallowed MR1 write (turn outputs off) together with a strobe rise
    @(negedge clk);
    cs_n = 1'b0; cmd = 3'b000; ba = 3'd1; addr = mr1(1, 1, 3'b001);
    dqs = 1'b1; mem_ck = 1'b1;
    @(negedge clk);
    cs_n = 1'b1; cmd = 3'b111; ba = '0; addr = '0; dqs = 1'b0;
    chk("R7 MR1 with level bit set flagged", illegal_cmd, 1);
    chk("R7 ignored write keeps outputs on", dq_oe, 1);
    tick(WLO + WLOE);
    chk("R5 capture in same cycle as bad command", dq_out, 8'hFF);
    @(negedge clk); cs_n = 1'b1; cmd = 3'b011;
    @(negedge clk); cmd = 3'b111;
    chk("R7 deselect not flagged", illegal_cmd, 0);
    tick(1);
    chk("R7 nop not flagged", illegal_cmd, 0);
  endtask

  task automatic t_exit;
    issue(3'b000, 3'd1, mr1(0, 0, 3'b001));
    chk("R1 exit drops dq_oe", dq_oe, 0);
    chk("R7 exit write not flagged", illegal_cmd, 0);
  endtask

  task automatic t_qoff;
    issue(3'b000, 3'd1, mr1(1, 1, 3'b100));
    chk("R2 outputs off keep dq_oe low", dq_oe, 0);
    chk("R8 any code legal with outputs off", rtt_bad, 0);
    chk("R9 entry clears held value", dq_out, 0);
    pulse_chk(1'b1, 8'h00, "R2 capture continues with outputs off");
    chk("R2 dq_oe still low", dq_oe, 0);
    issue(3'b000, 3'd1, mr1(0, 0, 3'b000));
  endtask

  task automatic t_rtt;
    issue(3'b000, 3'd1, mr1(1, 0, 3'b100));
    chk("R8 RZQ/12 code illegal with outputs on", rtt_bad, 1);
    chk("R9 re-entry clears held value", dq_out, 0);
    issue(3'b000, 3'd1, mr1(0, 0, 3'b000));
    chk("R8 flag clears on exit", rtt_bad, 0);
    issue(3'b000, 3'd1, mr1(1, 0, 3'b000));
    chk("R8 disabled code illegal with outputs on", rtt_bad, 1);
    issue(3'b000, 3'd1, mr1(0, 0, 3'b000));
    issue(3'b000, 3'd1, mr1(1, 0, 3'b011));
    chk("R8 RZQ/6 legal", rtt_bad, 0);
    issue(3'b000, 3'd1, mr1(0, 0, 3'b000));
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; cmd = 3'b111; ba = '0; addr = '0;
    mem_ck = 1'b0; dqs = 1'b0; odt = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_outside();
    t_enter_term();
    t_sample();
    t_illegal();
    t_exit();
    t_qoff();
    t_rtt();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule